// File: doc/BRIEF.md
# I2C Controller Mode and Enable Register

This block holds the 8-bit control byte of an I2C controller. The CPU writes it and reads it back. The bus engine feeds it events, and the block applies their side effects to the stored mode. The upper nibble has four fields: an interface enable, an interrupt enable, a master-select bit and a transmit-select bit. The last two together give one of four operating modes. The lower nibble is unused here and always reads as zero.

The engine reports five things: whether a transfer is in progress, when a transfer finishes, a lost arbitration, a detected start condition, and the direction bit of the address frame. From these the block changes the mode in hardware. It drops out of master on arbitration loss. In slave receive it takes the direction from the first frame after a start. It also holds back a CPU change of direction until the running transfer ends. The outputs are the current mode, the enable, the gated interrupt request and two register-bank selects. One select is for the slave address registers and the other is for the mode and data registers.

Top module: `i2c_mode_ctl`

## Requirements
- R1: After reset the read value is 0x00, the mode is 00 and the address-register bank is selected.
- R2: The mode output is {master_select, transmit_select}, read at bits 5 and 4: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. Bit 7 is the enable and bit 6 is the interrupt enable.
- R3: While the enable is 0, the mode is held at 00 and a pending direction write is discarded. A write that clears the enable takes effect in the same cycle.
- R4: The interrupt output equals the incoming request ANDed with the interrupt-enable bit.
- R5: The address-bank select is high exactly when the enable is 0, and the data-bank select is high exactly when the enable is 1.
- R6: Arbitration loss while master-select is 1 clears both mode bits on the next cycle.
- R7: In slave receive, an address frame that arrives after a start condition loads its R/W bit into transmit-select (1 gives slave transmit). A frame with no start before it has no effect.
- R8: A CPU write while a transfer is active and not ending leaves transmit-select unchanged. The written value is applied in the cycle the transfer-done pulse arrives.
- R9: A second deferred write before completion replaces the first one.
- R10: When arbitration loss coincides with the completion of a deferred write, arbitration loss wins. The pending value is discarded and is not applied by a later done pulse.
- R11: Bits 3 to 0 always read 0, and values written to them are ignored.
- R12: The enable, interrupt-enable and master-select fields of a write take effect at once, even during a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Register read value |
| xfer_active_i | input | 1 | A transfer is in progress |
| xfer_done_i | input | 1 | Transfer completion pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| start_det_i | input | 1 | Start condition detected |
| addr_valid_i | input | 1 | Address frame received |
| addr_rw_i | input | 1 | R/W bit of the address frame |
| irq_req_i | input | 1 | Raw interrupt request from the engine |
| irq_o | output | 1 | Gated interrupt request to the CPU |
| enable_o | output | 1 | Interface enable |
| mode_o | output | 2 | {master, transmit} mode code |
| addr_bank_sel_o | output | 1 | Slave address registers selected |
| data_bank_sel_o | output | 1 | Mode and data registers selected |

## Verification
A lost or stale deferred write only shows up later. The read value and mode_o differ from the expected value in the first cycle after a done pulse, or they fail to differ when the pending state should have been discarded. A wrong first-frame arming flag shows up one cycle after the address frame, as the wrong slave direction. The bench keeps its own model of the pending and arming state and compares all outputs in every cycle. Each fault therefore shows up within a cycle of the event that exposes it.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned BIT_EN  = 7;
  localparam int unsigned BIT_IE  = 6;
  localparam int unsigned BIT_MS  = 5;
  localparam int unsigned BIT_TRS = 4;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;
endpackage

// File: rtl/i2c_mode_pend.sv
module i2c_mode_pend #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         drop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/i2c_mode_arm.sv
module i2c_mode_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_o <= 1'b0;
    else if (clr_i)  armed_o <= 1'b0;
    else if (set_i)  armed_o <= 1'b1;
  end
endmodule

// File: rtl/i2c_mode_ctl.sv
module i2c_mode_ctl
  import i2c_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             xfer_active_i,
  input  logic             xfer_done_i,
  input  logic             arb_lost_i,
  input  logic             start_det_i,
  input  logic             addr_valid_i,
  input  logic             addr_rw_i,
  input  logic             irq_req_i,
  output logic             irq_o,
  output logic             enable_o,
  output logic [1:0]       mode_o,
  output logic             addr_bank_sel_o,
  output logic             data_bank_sel_o
);
  logic en_q, ie_q, ms_q, trs_q;
  logic en_d, ie_d, ms_d, trs_d;
  logic pend_vld, pend_val;
  logic armed;
  logic defer_wr, pend_apply, arb_hit, frame_hit, pend_drop;

  assign defer_wr   = wr_en_i && xfer_active_i && !xfer_done_i;
  assign arb_hit    = arb_lost_i && en_q && ms_q;
  assign frame_hit  = addr_valid_i && armed && en_q && !ms_q && !trs_q;
  assign pend_apply = xfer_done_i && pend_vld;

  always_comb begin
    en_d  = en_q;
    ie_d  = ie_q;
    ms_d  = ms_q;
    trs_d = trs_q;
    if (pend_apply) trs_d = pend_val;
    if (wr_en_i) begin
      en_d = wr_data_i[BIT_EN];
      ie_d = wr_data_i[BIT_IE];
      ms_d = wr_data_i[BIT_MS];
      if (!defer_wr) trs_d = wr_data_i[BIT_TRS];
    end
    if (frame_hit) trs_d = addr_rw_i;
    if (arb_hit) begin
      ms_d  = 1'b0;
      trs_d = 1'b0;
    end
    if (!en_d) begin
      ms_d  = 1'b0;
      trs_d = 1'b0;
    end
  end

  // pending is dropped by disable, arbitration loss, its own use, or a direct write
  assign pend_drop = !en_d || arb_hit || (wr_en_i && !defer_wr) || (pend_apply && !defer_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      ms_q  <= 1'b0;
      trs_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ie_q  <= ie_d;
      ms_q  <= ms_d;
      trs_q <= trs_d;
    end
  end

  i2c_mode_pend #(.W(1)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (defer_wr),
    .data_i  (wr_data_i[BIT_TRS]),
    .drop_i  (pend_drop),
    .valid_o (pend_vld),
    .data_o  (pend_val)
  );

  i2c_mode_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (start_det_i && en_d),
    .clr_i   (!en_d || addr_valid_i),
    .armed_o (armed)
  );

  assign rd_data_o       = {en_q, ie_q, ms_q, trs_q, 4'b0000};
  assign mode_o          = {ms_q, trs_q};
  assign enable_o        = en_q;
  assign irq_o           = irq_req_i && ie_q;
  assign addr_bank_sel_o = !en_q;
  assign data_bank_sel_o = en_q;
endmodule

// File: rtl/i2c_mode_ctl_chk.sv
module i2c_mode_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       xfer_active_i,
  input logic       xfer_done_i,
  input logic       arb_lost_i,
  input logic       addr_valid_i,
  input logic       irq_req_i,
  input logic       irq_o,
  input logic       enable_o,
  input logic [1:0] mode_o,
  input logic       addr_bank_sel_o,
  input logic       data_bank_sel_o
);
  a_r3_disabled_slave_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |-> mode_o == 2'b00);

  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[6] |-> !irq_o);

  a_r5_bank_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_bank_sel_o != data_bank_sel_o);

  a_r6_arb_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && mode_o[1] && arb_lost_i) |=> mode_o == 2'b00);

  a_r8_trs_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[7] && xfer_active_i && !xfer_done_i && !arb_lost_i && !addr_valid_i)
      |=> $stable(mode_o[0]));

  a_r11_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3:0] == 4'b0000);
endmodule

bind i2c_mode_ctl i2c_mode_ctl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o),
  .xfer_active_i   (xfer_active_i),
  .xfer_done_i     (xfer_done_i),
  .arb_lost_i      (arb_lost_i),
  .addr_valid_i    (addr_valid_i),
  .irq_req_i       (irq_req_i),
  .irq_o           (irq_o),
  .enable_o        (enable_o),
  .mode_o          (mode_o),
  .addr_bank_sel_o (addr_bank_sel_o),
  .data_bank_sel_o (data_bank_sel_o)
);

// File: tb/i2c_mode_ctl_tb.sv
module i2c_mode_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, act = 0, done = 0, arb = 0, st = 0, av = 0, rw = 0, irq_in = 0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic irq, en, abank, dbank;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0;
  bit m_en, m_ie, m_ms, m_trs, m_pv, m_pd, m_arm;

  always #4 clk = ~clk;

  i2c_mode_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd),
    .xfer_active_i(act), .xfer_done_i(done), .arb_lost_i(arb), .start_det_i(st),
    .addr_valid_i(av), .addr_rw_i(rw), .irq_req_i(irq_in), .irq_o(irq),
    .enable_o(en), .mode_o(mode), .addr_bank_sel_o(abank), .data_bank_sel_o(dbank)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {m_en, m_ie, m_ms, m_trs, 4'b0};
  endfunction

  // bench model of the requirements
  task automatic model_step();
    bit defer, n_en, n_ie, n_ms, n_trs, n_pv, n_pd, arbh, frm;
    defer = wr && act && !done;
    arbh = arb && m_en && m_ms;
    frm = av && m_arm && m_en && !m_ms && !m_trs;
    n_en = m_en; n_ie = m_ie; n_ms = m_ms; n_trs = m_trs; n_pv = m_pv; n_pd = m_pd;
    if (done && m_pv) begin n_trs = m_pd; n_pv = 0; end
    if (wr) begin
      n_en = wd[7]; n_ie = wd[6]; n_ms = wd[5];
      if (defer) begin n_pv = 1; n_pd = wd[4]; end
      else begin n_trs = wd[4]; n_pv = 0; end
    end
    if (frm) n_trs = rw;
    if (arbh) begin n_ms = 0; n_trs = 0; n_pv = 0; end
    if (!n_en) begin n_ms = 0; n_trs = 0; n_pv = 0; end
    if (!n_en || av) m_arm = 0; else if (st) m_arm = 1;
    m_en = n_en; m_ie = n_ie; m_ms = n_ms; m_trs = n_trs; m_pv = n_pv; m_pd = n_pd;
  endtask

  task automatic cyc(bit w, logic [7:0] d, bit a, bit dn, bit ar, bit s, bit v, bit r);
    @(negedge clk);
    wr = w; wd = d; act = a; done = dn; arb = ar; st = s; av = v; rw = r;
    @(posedge clk);
    model_step();
    #1;
    chk("R2 read", rd, exp_rd());
    chk("R2 mode", {6'b0, mode}, {6'b0, m_ms, m_trs});
    chk("R5 bank", {6'b0, abank, dbank}, {6'b0, !m_en, m_en});
    chk("R4 irq", {7'b0, irq}, {7'b0, irq_in & m_ie});
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset read", rd, 8'h00);
    chk("R1 reset bank", {7'b0, abank}, 8'h01);
    @(negedge clk); rst_n = 1;

    cyc(1, 8'h80, 0, 0, 0, 0, 0, 0);
    chk("R5 enabled bank", {6'b0, abank, dbank}, 8'h01);
    cyc(1, 8'hB0, 0, 0, 0, 0, 0, 0);
    chk("R2 master tx", {6'b0, mode}, 8'h03);
    cyc(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    chk("R11 low nibble", rd, 8'hF0);
    irq_in = 1; idle();
    chk("R4 irq passes", {7'b0, irq}, 8'h01);
    cyc(1, 8'hB0, 0, 0, 0, 0, 0, 0);
    chk("R4 irq blocked", {7'b0, irq}, 8'h00);
    irq_in = 0;

    // R8: deferred direction write
    cyc(1, 8'hA0, 1, 0, 0, 0, 0, 0);
    chk("R8 held", {6'b0, mode}, 8'h03);
    cyc(0, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 applied", {6'b0, mode}, 8'h02);
    // R9: replacement
    cyc(1, 8'hB0, 0, 0, 0, 0, 0, 0);
    cyc(1, 8'hA0, 1, 0, 0, 0, 0, 0);
    cyc(1, 8'hB0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 0, 0);
    chk("R9 replaced", {6'b0, mode}, 8'h03);
    // R10: arbitration beats pending
    cyc(1, 8'hA0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 1, 0, 0, 0);
    chk("R10 arb wins", {6'b0, mode}, 8'h00);
    cyc(1, 8'hB0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 pending gone", {6'b0, mode}, 8'h03);
    // R6
    cyc(1, 8'hA0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 0, 0, 0);
    chk("R6 arb clears", {6'b0, mode}, 8'h00);
    // R7
    cyc(1, 8'h80, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 unarmed ignored", {6'b0, mode}, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 1, 1);
    chk("R7 slave tx", {6'b0, mode}, 8'h01);
    // R12
    cyc(1, 8'hB0, 1, 0, 0, 0, 0, 0);
    chk("R12 master immediate", {6'b0, mode}, 8'h03);
    // R3
    cyc(1, 8'hA0, 1, 0, 0, 0, 0, 0);
    cyc(1, 8'h00, 1, 0, 0, 0, 0, 0);
    chk("R3 disabled mode", {6'b0, mode}, 8'h00);
    chk("R3 address bank", {7'b0, abank}, 8'h01);
    cyc(1, 8'h80, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 pending dropped", {6'b0, mode}, 8'h00);

    // random phase, compared against the model each cycle
    for (int i = 0; i < 2000; i++) begin
      bit a;
      a = ($urandom % 3) != 0;
      irq_in = $urandom % 2;
      cyc(($urandom % 4) == 0, 8'($urandom), a, a && (($urandom % 5) == 0),
          ($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0, $urandom % 2);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule